// File: doc/BRIEF.md
# Indirect Interrupt Router Register Window

This block holds the software-visible state of an interrupt router and gives the host access to it through two 32-bit bus locations. One location is a select register that names an internal register. The other is a data window that reads or writes whichever register is selected. Behind the window are a small identification register, a constant version word, an arbitration word that always reads as zero, and one 64-bit redirection entry per interrupt pin. Each entry is reached as two 32-bit halves.

The whole redirection table is driven in parallel to a delivery engine. Any write that lands in the table raises a single-cycle service request, so the engine rescans pending interrupts against the new settings. Reads return data one cycle after the read strobe. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `irq_window_regs`

## Requirements
- R1: The 8-bit byte offset `busAddr` decodes only 0x00 (select register) and 0x10 (data window). A read of any other offset returns zero. A write to any other offset changes no register and raises no service request.
- R2: A write to offset 0x00 stores `busWdata[7:0]` as the select value. A read of offset 0x00 returns that value zero-extended to 32 bits. Read data from any offset appears on `busRdata` in the cycle after `busRe` is sampled.
- R3: With select 0, a window write stores `busWdata[27:24]` as the 4-bit ID. A window read returns the ID in bits 27:24, with zeros in all other bits.
- R4: With select 1, a window read returns 0x11 in bits 7:0 and NUM_PINS-1 in bits 23:16, with zeros elsewhere. Writes have no effect.
- R5: With select 2, a window read returns zero and writes have no effect.
- R6: Redirection entry n is selected by the value 0x10+2n. The even value covers entry bits 31:0 and the odd value covers bits 63:32. A window write replaces only the addressed half. Entry n appears on `entryTable[64n+63:64n]`.
- R7: Select values 3 to 0x0F, and values at or above 0x10+2*NUM_PINS, read as zero through the window. Writes at those values change no entry and raise no service request.
- R8: `svcReq` is high for exactly the cycle after each window write that targets a redirection entry, and is low at all other times.
- R9: After reset, the select value and the ID are zero, and every redirection entry equals 0x0000_0000_0001_0000 (only the mask bit, bit 16, set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the access |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRe |
| entryTable | output | 64*NUM_PINS | All redirection entries, entry n in bits 64n+63:64n |
| svcReq | output | 1 | One-cycle rescan request after an entry write |

## Verification
The checker verifies on every cycle the read-side contracts that follow from the current select value alone: the zero-extended select readback, the ID field shape, the version constant, the zero arbitration word, and zeros for unmapped offsets and unmapped select values. It also checks that the table never moves without an entry write, and that the service request follows entry writes one-for-one. The bench scenarios alone show that data actually lands in the addressed half and leaves the other half untouched, the exact reset contents of every entry, and that writes to the version, arbitration, gap and beyond-table indices leave all state unchanged.

// File: rtl/iwr_pkg.sv
package iwr_pkg;

  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam logic [7:0] IDX_TBL = 8'h10;

  localparam logic [7:0] VER_CODE = 8'h11;
  localparam int         ID_LSB   = 24;
  localparam int         ID_W     = 4;
  localparam int         MASK_BIT = 16;
  localparam logic [63:0] ENT_RST = 64'h1 << MASK_BIT;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_SEL,
    RD_ID,
    RD_VER,
    RD_ENT
  } rdSrc_e;

  typedef struct packed {
    logic       selWr;
    logic       idWr;
    logic       entWr;
    logic       entHi;
    logic [6:0] entIdx;
    logic       rdEn;
    rdSrc_e     rdSrc;
  } strobe_t;

endpackage

// File: rtl/iwr_ctrl.sv
module iwr_ctrl
  import iwr_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic [7:0] busAddr,
  input  logic       busWe,
  input  logic       busRe,
  input  logic [7:0] selReg,
  output strobe_t    strb
);

  localparam int TBL_END = int'(IDX_TBL) + 2 * NUM_PINS;

  logic selHit;
  logic winHit;
  logic entHit;

  assign selHit = (busAddr == OFS_SEL);
  assign winHit = (busAddr == OFS_WIN);
  assign entHit = (selReg >= IDX_TBL) && (int'(selReg) < TBL_END);

  always_comb begin
    strb        = '0;
    strb.selWr  = busWe && selHit;
    strb.idWr   = busWe && winHit && (selReg == IDX_ID);
    strb.entWr  = busWe && winHit && entHit;
    strb.entHi  = selReg[0];
    strb.entIdx = selReg[7:1] - IDX_TBL[7:1];
    strb.rdEn   = busRe;
    if (selHit) begin
      strb.rdSrc = RD_SEL;
    end else if (winHit) begin
      if (selReg == IDX_ID)       strb.rdSrc = RD_ID;
      else if (selReg == IDX_VER) strb.rdSrc = RD_VER;
      else if (entHit)            strb.rdSrc = RD_ENT;
      else                        strb.rdSrc = RD_NONE;
    end else begin
      strb.rdSrc = RD_NONE;
    end
  end

endmodule

// File: rtl/iwr_datapath.sv
module iwr_datapath
  import iwr_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [31:0]           busWdata,
  output logic [7:0]            selReg,
  output logic [31:0]           busRdata,
  output logic [64*NUM_PINS-1:0] entryTable,
  output logic                  svcReq
);

  localparam logic [7:0] PIN_MAX = 8'(NUM_PINS - 1);

  logic [ID_W-1:0] idReg;
  logic [63:0]     entries [NUM_PINS];
  logic [63:0]     entRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
      idReg  <= '0;
      svcReq <= 1'b0;
    end else begin
      if (strb.selWr) selReg <= busWdata[7:0];
      if (strb.idWr)  idReg  <= busWdata[ID_LSB +: ID_W];
      svcReq <= strb.entWr;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entries[g] <= ENT_RST;
      end else if (strb.entWr && (strb.entIdx == 7'(g))) begin
        if (strb.entHi) entries[g][63:32] <= busWdata;
        else            entries[g][31:0]  <= busWdata;
      end
    end
    assign entryTable[64*g +: 64] = entries[g];
  end

  always_comb begin
    entRd = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (strb.entIdx == 7'(i)) entRd = entries[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSrc)
        RD_SEL:  busRdata <= {24'h0, selReg};
        RD_ID:   busRdata <= {4'h0, idReg, 24'h0};
        RD_VER:  busRdata <= {8'h0, PIN_MAX, 8'h0, VER_CODE};
        RD_ENT:  busRdata <= strb.entHi ? entRd[63:32] : entRd[31:0];
        default: busRdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_window_regs.sv
module irq_window_regs
  import iwr_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             busAddr,
  input  logic                   busWe,
  input  logic                   busRe,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  output logic [64*NUM_PINS-1:0] entryTable,
  output logic                   svcReq
);

  initial begin
    if (NUM_PINS < 1 || NUM_PINS > 120) $error("NUM_PINS out of range");
  end

  strobe_t    strb;
  logic [7:0] selReg;

  iwr_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .selReg  (selReg),
    .strb    (strb)
  );

  iwr_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .selReg     (selReg),
    .busRdata   (busRdata),
    .entryTable (entryTable),
    .svcReq     (svcReq)
  );

endmodule

// File: rtl/iwr_checker.sv
module iwr_checker #(
  parameter int NUM_PINS = 24
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [7:0]             busAddr,
  input logic                   busWe,
  input logic                   busRe,
  input logic [31:0]            busRdata,
  input logic [64*NUM_PINS-1:0] entryTable,
  input logic                   svcReq,
  input logic [7:0]             selReg
);

  localparam int TBL_END = 16 + 2 * NUM_PINS;
  localparam logic [31:0] VER_WORD = {8'h0, 8'(NUM_PINS - 1), 8'h0, 8'h11};

  logic winAcc;
  logic selIsEnt;
  assign winAcc   = (busAddr == 8'h10);
  assign selIsEnt = (selReg >= 8'h10) && (int'(selReg) < TBL_END);

  p_other_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr != 8'h00 && !winAcc) |=> (busRdata == 32'h0));

  p_sel_zext_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == 8'h00) |=> (busRdata[31:8] == 24'h0));

  p_id_field_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && winAcc && selReg == 8'h00) |=>
      (busRdata[31:28] == 4'h0 && busRdata[23:0] == 24'h0));

  p_ver_const_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && winAcc && selReg == 8'h01) |=> (busRdata == VER_WORD));

  p_arb_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && winAcc && selReg == 8'h02) |=> (busRdata == 32'h0));

  p_table_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && winAcc && selIsEnt) |=> $stable(entryTable));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && winAcc && selReg > 8'h02 && !selIsEnt) |=> (busRdata == 32'h0));

  p_svc_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && winAcc && selIsEnt) |=> svcReq);

  p_svc_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    svcReq |-> $past(busWe && winAcc && selIsEnt));

endmodule

bind irq_window_regs iwr_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWe      (busWe),
  .busRe      (busRe),
  .busRdata   (busRdata),
  .entryTable (entryTable),
  .svcReq     (svcReq),
  .selReg     (selReg)
);

// File: tb/irq_window_regs_tb.sv
module irq_window_regs_tb;

  localparam int NP = 24;
  localparam logic [63:0] RST_ENT = 64'h0000_0000_0001_0000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [7:0]          busAddr = '0;
  logic                busWe = 1'b0;
  logic                busRe = 1'b0;
  logic [31:0]         busWdata = '0;
  logic [31:0]         busRdata;
  logic [64*NP-1:0]    entryTable;
  logic                svcReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  irq_window_regs #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .entryTable(entryTable),
    .svcReq(svcReq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, output logic svc);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    svc = svcReq;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic winRead(input logic [7:0] sel, output logic [31:0] d);
    logic s;
    busWrite(8'h00, {24'h0, sel}, s);
    busRead(8'h10, d);
  endtask

  task automatic winWrite(input logic [7:0] sel, input logic [31:0] v, output logic svc);
    logic s;
    busWrite(8'h00, {24'h0, sel}, s);
    busWrite(8'h10, v, svc);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    busRead(8'h00, d);
    chk("R9 select after reset", d, 0);
    chk("R8 no svc after reset", svcReq, 0);
    for (int i = 0; i < NP; i++)
      chk("R9 entry reset value", entryTable[64*i +: 64], RST_ENT);
    busRead(8'h10, d);
    chk("R9 id after reset", d, 0);
  endtask

  task automatic t_select;
    logic [31:0] d;
    logic s;
    busWrite(8'h00, 32'hFFFF_FFAB, s);
    chk("R8 no svc on select write", s, 0);
    busRead(8'h00, d);
    chk("R2 select zero-extended", d, 32'h0000_00AB);
  endtask

  task automatic t_id;
    logic [31:0] d;
    logic s;
    winWrite(8'h00, 32'hFFFF_FFFF, s);
    chk("R3 no svc on id write", s, 0);
    busRead(8'h10, d);
    chk("R3 id field only", d, 32'h0F00_0000);
    winWrite(8'h00, 32'h0500_0000, s);
    busRead(8'h10, d);
    chk("R3 id rewrite", d, 32'h0500_0000);
  endtask

  task automatic t_ver_arb;
    logic [31:0] d;
    logic s;
    winRead(8'h01, d);
    chk("R4 version word", d, 32'h0017_0011);
    winWrite(8'h01, 32'h1234_5678, s);
    busRead(8'h10, d);
    chk("R4 version ignores write", d, 32'h0017_0011);
    winWrite(8'h02, 32'hFFFF_FFFF, s);
    chk("R5 no svc on arb write", s, 0);
    busRead(8'h10, d);
    chk("R5 arbitration zero", d, 0);
  endtask

  task automatic t_halves;
    logic [31:0] d;
    logic s;
    winWrite(8'h10, 32'h0000_A5C3, s);
    chk("R8 svc after low-half write", s, 1);
    @(negedge clk);
    chk("R8 svc single cycle", svcReq, 0);
    chk("R6 entry0 low replaced", entryTable[63:0], 64'h0000_0000_0000_A5C3);
    busRead(8'h10, d);
    chk("R6 entry0 low readback", d, 32'h0000_A5C3);
    winWrite(8'h3F, 32'hDEAD_BEEF, s);
    chk("R8 svc after high-half write", s, 1);
    chk("R6 entry23 high only", entryTable[64*23 +: 64], 64'hDEAD_BEEF_0001_0000);
    busRead(8'h10, d);
    chk("R6 entry23 high readback", d, 32'hDEAD_BEEF);
    winRead(8'h3E, d);
    chk("R6 entry23 low untouched", d, 32'h0001_0000);
    chk("R6 neighbour entry1 untouched", entryTable[127:64], RST_ENT);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic s;
    logic [64*NP-1:0] snap;
    snap = entryTable;
    winWrite(8'h40, 32'h1234_5678, s);
    chk("R7 no svc past table", s, 0);
    busRead(8'h10, d);
    chk("R7 past-table read zero", d, 0);
    winWrite(8'h07, 32'h1234_5678, s);
    chk("R7 no svc in gap", s, 0);
    busRead(8'h10, d);
    chk("R7 gap read zero", d, 0);
    winWrite(8'hFF, 32'hFFFF_FFFF, s);
    chk("R7 table unchanged", entryTable, snap);
  endtask

  task automatic t_offsets;
    logic [31:0] d;
    logic s;
    logic [64*NP-1:0] snap;
    busWrite(8'h00, 32'h0000_0010, s);
    snap = entryTable;
    busWrite(8'h04, 32'h0000_0033, s);
    chk("R1 no svc on other offset", s, 0);
    busRead(8'h00, d);
    chk("R1 select unchanged by other offset", d, 32'h10);
    busWrite(8'h14, 32'hFFFF_FFFF, s);
    chk("R1 table unchanged by other offset", entryTable, snap);
    busRead(8'h04, d);
    chk("R1 other offset reads zero", d, 0);
    busRead(8'h11, d);
    chk("R1 near-window offset reads zero", d, 0);
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_select;
    t_id;
    t_ver_arb;
    t_halves;
    t_unmapped;
    t_offsets;
    done = 1'b1;
    finishRun;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun;
    end
  end

endmodule